// File: doc/BRIEF.md
# Bank-Switchable Dual-Port Memory

This block is a synchronous memory with two fully independent ports. Each port has its own clock, address, data and controls. The storage is divided into whole banks, and each port picks a bank on every cycle through a bank-address input. Either port may use any bank that the other port is not using in the same cycle. Keeping the two ports in different banks is the system's job: no two ports ever touch the same cell at once. A word written through one port can later be read back through the other.

Every port captures its inputs on the rising edge of its own clock. A write takes effect at that same edge. Each port has a burst address counter that can be loaded by a strobe, stepped, or sent back to the last strobed word. Each port also chooses its own read latency. Flow-through mode gives data in the cycle after capture, and pipelined mode adds one more register. Four byte lanes of 9 bits each gate both writes and reads. An asynchronous output enable blanks the read bus.

Top module: `bswdp_top`

## Requirements
- R1: A write (select active, `xRdWrN`=0) is stored at the rising edge that captures it, and a read of that word on any later edge returns it.
- R2: A port is selected only when `xCe0N`=0 and `xCe1`=1. When it is deselected at an edge, the port writes nothing, its counter and strobed address are held, and its flow-through output is zero after that edge.
- R3: Both ports may run at the same time in different banks without affecting each other, and each port can read words held in banks written by the other port.
- R4: Byte enable bit i (`xBeN[i]`=0 means active) controls lane i, which is data bits 9i+8 down to 9i. A write changes only the active lanes. A read returns zero in the inactive lanes.
- R5: With `xPipe`=0 (flow-through), read data for an access captured at edge k appears after edge k and stays until edge k+1.
- R6: With `xPipe`=1 (pipelined), read data for an access captured at edge k appears after edge k+1, one cycle later than in flow-through mode.
- R7: With `xAdsN`=0, the access uses word `xAddr`, which is also kept as the strobed address. The strobe has priority over repeat and count.
- R8: With `xAdsN`=1, `xRptN`=1 and `xCntEnN`=0, the access uses the previous word plus one, wrapping modulo the bank size inside the bank. With all three high, it uses the previous word again. The bank always comes from `xBank` in the current cycle.
- R9: With `xAdsN`=1 and `xRptN`=0, the access uses the last strobed word. Repeat has priority over count.
- R10: `xOeN`=1 forces `xDout` to zero at once, without waiting for a clock edge. `xOeN`=0 shows the read data.
- R11: While and after `rstN` is low, both outputs are zero and both counters and strobed addresses are zero.
- R12: Each lane of a read returns the value from the most recent write to that lane, whichever port performed the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aClk | input | 1 | Port A clock |
| bClk | input | 1 | Port B clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aCe0N | input | 1 | Port A enable, active low |
| aCe1 | input | 1 | Port A enable, active high |
| aRdWrN | input | 1 | Port A: 1 read, 0 write |
| aBeN | input | LANES | Port A lane enables, active low |
| aAdsN | input | 1 | Port A address strobe, active low |
| aCntEnN | input | 1 | Port A counter step, active low |
| aRptN | input | 1 | Port A repeat strobed address, active low |
| aBank | input | clog2(NUM_BANKS) | Port A bank select |
| aAddr | input | clog2(BANK_WORDS) | Port A word address |
| aDin | input | WORD_W | Port A write data |
| aPipe | input | 1 | Port A read mode: 1 pipelined, 0 flow-through |
| aOeN | input | 1 | Port A output enable, active low |
| aDout | output | WORD_W | Port A read data |
| bCe0N | input | 1 | Port B enable, active low |
| bCe1 | input | 1 | Port B enable, active high |
| bRdWrN | input | 1 | Port B: 1 read, 0 write |
| bBeN | input | LANES | Port B lane enables, active low |
| bAdsN | input | 1 | Port B address strobe, active low |
| bCntEnN | input | 1 | Port B counter step, active low |
| bRptN | input | 1 | Port B repeat strobed address, active low |
| bBank | input | clog2(NUM_BANKS) | Port B bank select |
| bAddr | input | clog2(BANK_WORDS) | Port B word address |
| bDin | input | WORD_W | Port B write data |
| bPipe | input | 1 | Port B read mode: 1 pipelined, 0 flow-through |
| bOeN | input | 1 | Port B output enable, active low |
| bDout | output | WORD_W | Port B read data |

## Verification
The bench builds the block with NUM_BANKS=4 and BANK_WORDS=16, which gives 64 words. With this size the bench can write and cross-read every word of every bank from both ports, run all 16 lane masks while the writing port alternates, and reach the counter wrap after only a few steps. Both latency modes are swept over a full bank, and the bench flags any edge at which both ports select the same bank.

// File: rtl/bswdp_pkg.sv
package bswdp_pkg;
  localparam int LANE_W = 9;

  typedef struct packed {
    logic act;
    logic wr;
    logic rd;
  } portStb_t;
endpackage

// File: rtl/bswdp_ctrl.sv
module bswdp_ctrl
  import bswdp_pkg::*;
#(
  parameter int WORD_AW = 6,
  parameter int BANK_AW = 3,
  parameter int LANES   = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ce0N,
  input  logic                       ce1,
  input  logic                       rdWrN,
  input  logic                       adsN,
  input  logic                       cntEnN,
  input  logic                       rptN,
  input  logic [LANES-1:0]           beN,
  input  logic [BANK_AW-1:0]         bankIn,
  input  logic [WORD_AW-1:0]         addrIn,
  output portStb_t                   stb,
  output logic [BANK_AW+WORD_AW-1:0] accAddr,
  output logic [LANES-1:0]           accLanes
);
  logic               sel;
  logic [WORD_AW-1:0] cntQ, loadQ, nextWord;

  assign sel = !ce0N && ce1;

  always_comb begin
    if (!adsN)        nextWord = addrIn;
    else if (!rptN)   nextWord = loadQ;
    else if (!cntEnN) nextWord = cntQ + 1'b1;
    else              nextWord = cntQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      loadQ <= '0;
    end else if (sel) begin
      cntQ <= nextWord;
      if (!adsN) loadQ <= addrIn;
    end
  end

  assign stb.act  = sel;
  assign stb.wr   = sel && !rdWrN;
  assign stb.rd   = sel && rdWrN;
  assign accAddr  = {bankIn, nextWord};
  assign accLanes = ~beN;

  // R7: a strobe loads the word address
  a_r7_strobe_load: assert property (@(posedge clk) disable iff (!rstN)
    sel && !adsN |=> cntQ == $past(addrIn));
  // R9: repeat returns to the strobed word
  a_r9_repeat: assert property (@(posedge clk) disable iff (!rstN)
    sel && adsN && !rptN |=> cntQ == $past(loadQ));
  // R8: count step wraps inside the bank
  a_r8_step: assert property (@(posedge clk) disable iff (!rstN)
    sel && adsN && rptN && !cntEnN |=> cntQ == WORD_AW'($past(cntQ) + 1));
  // R2: deselected port keeps its counter state
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sel |=> $stable(cntQ) && $stable(loadQ));
endmodule

// File: rtl/bswdp_bankset.sv
module bswdp_bankset #(
  parameter int DEPTH   = 512,
  parameter int AW      = 9,
  parameter int LANES   = 4,
  parameter int WORD_W  = 36,
  parameter bit TAG_INV = 1'b0
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [LANES-1:0]  wrLanes,
  input  logic [WORD_W-1:0] wrData,
  input  logic [LANES-1:0]  peerTag,
  input  logic [AW-1:0]     rdAddr0,
  input  logic [AW-1:0]     rdAddr1,
  input  logic [AW-1:0]     tagAddr,
  output logic [WORD_W-1:0] rdData0,
  output logic [WORD_W-1:0] rdData1,
  output logic [LANES-1:0]  rdTag0,
  output logic [LANES-1:0]  rdTag1,
  output logic [LANES-1:0]  tagOut
);
  localparam int LW = WORD_W / LANES;

  logic [WORD_W-1:0] store [DEPTH];
  logic [LANES-1:0]  tag   [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) begin
      for (int l = 0; l < LANES; l++) begin
        if (wrLanes[l]) begin
          store[wrAddr][l*LW +: LW] <= wrData[l*LW +: LW];
          tag[wrAddr][l]            <= peerTag[l] ^ TAG_INV;
        end
      end
    end
  end

  assign rdData0 = store[rdAddr0];
  assign rdData1 = store[rdAddr1];
  assign rdTag0  = tag[rdAddr0];
  assign rdTag1  = tag[rdAddr1];
  assign tagOut  = tag[tagAddr];
endmodule

// File: rtl/bswdp_datapath.sv
module bswdp_datapath
  import bswdp_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int AW     = 9,
  parameter int LANES  = 4,
  parameter int WORD_W = 36
) (
  input  logic [1:0]              clk,
  input  logic                    rstN,
  input  portStb_t [1:0]          stb,
  input  logic [1:0][AW-1:0]      addr,
  input  logic [1:0][LANES-1:0]   lanes,
  input  logic [1:0][WORD_W-1:0]  din,
  input  logic [1:0]              pipeMode,
  input  logic [1:0]              oeN,
  output logic [1:0][WORD_W-1:0]  dout
);
  localparam int LW = WORD_W / LANES;

  logic [1:0][1:0][WORD_W-1:0] rdData;
  logic [1:0][1:0][LANES-1:0]  rdTag;
  logic [1:0][LANES-1:0]       peerTag;
  logic [1:0][AW-1:0]          rdAddrArr;

  for (genvar p = 0; p < 2; p++) begin : g_set
    bswdp_bankset #(
      .DEPTH(DEPTH), .AW(AW), .LANES(LANES), .WORD_W(WORD_W), .TAG_INV(p == 0)
    ) u_set (
      .clk    (clk[p]),
      .wrEn   (stb[p].wr),
      .wrAddr (addr[p]),
      .wrLanes(lanes[p]),
      .wrData (din[p]),
      .peerTag(peerTag[1-p]),
      .rdAddr0(rdAddrArr[0]),
      .rdAddr1(rdAddrArr[1]),
      .tagAddr(addr[1-p]),
      .rdData0(rdData[p][0]),
      .rdData1(rdData[p][1]),
      .rdTag0 (rdTag[p][0]),
      .rdTag1 (rdTag[p][1]),
      .tagOut (peerTag[p])
    );
  end

  for (genvar q = 0; q < 2; q++) begin : g_port
    logic [AW-1:0]     rdAddrQ;
    logic [LANES-1:0]  rdLaneQ;
    logic [WORD_W-1:0] pipeQ;
    logic [WORD_W-1:0] flowData;

    always_ff @(posedge clk[q] or negedge rstN) begin
      if (!rstN) begin
        rdAddrQ <= '0;
        rdLaneQ <= '0;
        pipeQ   <= '0;
      end else begin
        rdAddrQ <= addr[q];
        rdLaneQ <= stb[q].rd ? lanes[q] : '0;
        pipeQ   <= flowData;
      end
    end

    always_comb begin
      for (int l = 0; l < LANES; l++) begin
        flowData[l*LW +: LW] = '0;
        if (rdLaneQ[l])
          flowData[l*LW +: LW] = (rdTag[0][q][l] ^ rdTag[1][q][l]) ?
                                 rdData[0][q][l*LW +: LW] : rdData[1][q][l*LW +: LW];
      end
    end

    assign rdAddrArr[q] = rdAddrQ;
    assign dout[q] = oeN[q] ? '0 : (pipeMode[q] ? pipeQ : flowData);

    // R10: disabled output bus reads as zero
    a_r10_oe_blank: assert property (@(posedge clk[q]) disable iff (!rstN)
      oeN[q] |-> dout[q] == '0);
    // R6: pipelined output trails the flow-through data by one edge
    a_r6_pipe_delay: assert property (@(posedge clk[q]) disable iff (!rstN)
      pipeMode[q] && !oeN[q] |-> dout[q] == $past(flowData));
    // R2: no read data after a deselected edge
    a_r2_desel_quiet: assert property (@(posedge clk[q]) disable iff (!rstN)
      !stb[q].act |=> pipeMode[q] || oeN[q] || dout[q] == '0);
  end
endmodule

// File: rtl/bswdp_top.sv
module bswdp_top
  import bswdp_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int BANK_WORDS = 64,
  parameter int WORD_W     = 36,
  parameter int LANES      = 4,
  localparam int BANK_AW   = $clog2(NUM_BANKS),
  localparam int WORD_AW   = $clog2(BANK_WORDS)
) (
  input  logic               aClk,
  input  logic               bClk,
  input  logic               rstN,
  input  logic               aCe0N,
  input  logic               aCe1,
  input  logic               aRdWrN,
  input  logic [LANES-1:0]   aBeN,
  input  logic               aAdsN,
  input  logic               aCntEnN,
  input  logic               aRptN,
  input  logic [BANK_AW-1:0] aBank,
  input  logic [WORD_AW-1:0] aAddr,
  input  logic [WORD_W-1:0]  aDin,
  input  logic               aPipe,
  input  logic               aOeN,
  output logic [WORD_W-1:0]  aDout,
  input  logic               bCe0N,
  input  logic               bCe1,
  input  logic               bRdWrN,
  input  logic [LANES-1:0]   bBeN,
  input  logic               bAdsN,
  input  logic               bCntEnN,
  input  logic               bRptN,
  input  logic [BANK_AW-1:0] bBank,
  input  logic [WORD_AW-1:0] bAddr,
  input  logic [WORD_W-1:0]  bDin,
  input  logic               bPipe,
  input  logic               bOeN,
  output logic [WORD_W-1:0]  bDout
);
  localparam int AW    = BANK_AW + WORD_AW;
  localparam int DEPTH = NUM_BANKS * BANK_WORDS;

  portStb_t [1:0]             stb;
  logic [1:0][AW-1:0]         accAddr;
  logic [1:0][LANES-1:0]      accLanes;
  logic [1:0][WORD_W-1:0]     dout;

  bswdp_ctrl #(.WORD_AW(WORD_AW), .BANK_AW(BANK_AW), .LANES(LANES)) u_ctrlA (
    .clk(aClk), .rstN(rstN), .ce0N(aCe0N), .ce1(aCe1), .rdWrN(aRdWrN),
    .adsN(aAdsN), .cntEnN(aCntEnN), .rptN(aRptN), .beN(aBeN),
    .bankIn(aBank), .addrIn(aAddr),
    .stb(stb[0]), .accAddr(accAddr[0]), .accLanes(accLanes[0])
  );

  bswdp_ctrl #(.WORD_AW(WORD_AW), .BANK_AW(BANK_AW), .LANES(LANES)) u_ctrlB (
    .clk(bClk), .rstN(rstN), .ce0N(bCe0N), .ce1(bCe1), .rdWrN(bRdWrN),
    .adsN(bAdsN), .cntEnN(bCntEnN), .rptN(bRptN), .beN(bBeN),
    .bankIn(bBank), .addrIn(bAddr),
    .stb(stb[1]), .accAddr(accAddr[1]), .accLanes(accLanes[1])
  );

  bswdp_datapath #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .WORD_W(WORD_W)) u_dp (
    .clk     ({bClk, aClk}),
    .rstN    (rstN),
    .stb     (stb),
    .addr    (accAddr),
    .lanes   (accLanes),
    .din     ({bDin, aDin}),
    .pipeMode({bPipe, aPipe}),
    .oeN     ({bOeN, aOeN}),
    .dout    (dout)
  );

  assign aDout = dout[0];
  assign bDout = dout[1];

  // R3: the two ports never hold the same bank at once
  a_r3_bank_exclusive: assert property (@(posedge aClk) disable iff (!rstN)
    stb[0].act && stb[1].act |-> accAddr[0][AW-1 -: BANK_AW] != accAddr[1][AW-1 -: BANK_AW]);
endmodule

// File: tb/test_bswdp_top.sv
module test_bswdp_top;
  localparam int NB = 4;
  localparam int BW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aCe0N = 1'b1, aCe1 = 1'b1, aRdWrN = 1'b1, aAdsN = 1'b1, aCntEnN = 1'b1, aRptN = 1'b1;
  logic bCe0N = 1'b1, bCe1 = 1'b1, bRdWrN = 1'b1, bAdsN = 1'b1, bCntEnN = 1'b1, bRptN = 1'b1;
  logic [3:0]  aBeN = '1, bBeN = '1;
  logic [1:0]  aBank = '0, bBank = '0;
  logic [3:0]  aAddr = '0, bAddr = '0;
  logic [35:0] aDin = '0, bDin = '0;
  logic aPipe = 1'b0, bPipe = 1'b0, aOeN = 1'b0, bOeN = 1'b0;
  logic [35:0] aDout, bDout;

  logic [35:0] refMem [NB*BW];
  int cmp = 0;
  int mis = 0;

  always #2 clk = ~clk;

  bswdp_top #(.NUM_BANKS(NB), .BANK_WORDS(BW)) i_bswdp_top (
    .aClk(clk), .bClk(clk), .rstN(rstN),
    .aCe0N(aCe0N), .aCe1(aCe1), .aRdWrN(aRdWrN), .aBeN(aBeN), .aAdsN(aAdsN),
    .aCntEnN(aCntEnN), .aRptN(aRptN), .aBank(aBank), .aAddr(aAddr), .aDin(aDin),
    .aPipe(aPipe), .aOeN(aOeN), .aDout(aDout),
    .bCe0N(bCe0N), .bCe1(bCe1), .bRdWrN(bRdWrN), .bBeN(bBeN), .bAdsN(bAdsN),
    .bCntEnN(bCntEnN), .bRptN(bRptN), .bBank(bBank), .bAddr(bAddr), .bDin(bDin),
    .bPipe(bPipe), .bOeN(bOeN), .bDout(bDout)
  );

  function automatic logic [35:0] pat(int bk, int wd, int s);
    return {4'(s), 4'(bk), 4'(wd), 24'(wd * 40503 + bk * 977 + s * 131)};
  endfunction

  function automatic logic [35:0] lm(logic [3:0] m);
    logic [35:0] r = '0;
    for (int l = 0; l < 4; l++) if (m[l]) r[l*9 +: 9] = '1;
    return r;
  endfunction

  task automatic check(string req, logic [35:0] act, logic [35:0] exp);
    cmp++;
    if (act !== exp) begin
      mis++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // ce: 0 selected, 1 first enable off, 2 second enable off
  task automatic drv(int p, int ce, bit wr, int bk, int wd, logic [3:0] ln,
                     bit ads, bit cnt, bit rpt, logic [35:0] d);
    if (p == 0) begin
      aCe0N = (ce == 1); aCe1 = (ce != 2); aRdWrN = !wr; aBeN = ~ln;
      aAdsN = !ads; aCntEnN = !cnt; aRptN = !rpt;
      aBank = 2'(bk); aAddr = 4'(wd); aDin = d;
    end else begin
      bCe0N = (ce == 1); bCe1 = (ce != 2); bRdWrN = !wr; bBeN = ~ln;
      bAdsN = !ads; bCntEnN = !cnt; bRptN = !rpt;
      bBank = 2'(bk); bAddr = 4'(wd); bDin = d;
    end
  endtask

  task automatic idle(int p);
    drv(p, 1, 1'b0, 0, 0, 4'h0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic wrRef(int bk, int wd, logic [3:0] ln, logic [35:0] d);
    refMem[bk*BW + wd] = (refMem[bk*BW + wd] & ~lm(ln)) | (d & lm(ln));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, mis);
    $finish;
  endtask

  // usage monitor: both ports in one bank on one edge
  always @(posedge clk) begin
    if (rstN && !aCe0N && aCe1 && !bCe0N && bCe1 && aBank == bBank) begin
      mis++;
      $display("FAIL R3: bank %0d used by both ports, expected distinct banks", aBank);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    mis++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NB*BW; i++) refMem[i] = '0;
    repeat (3) @(negedge clk);
    check("R11 reset A", aDout, '0);
    check("R11 reset B", bDout, '0);
    rstN = 1'b1;
    tick();
    check("R11 after reset A", aDout, '0);

    // fill: A owns banks 0,1 and B owns banks 2,3, concurrently
    for (int w = 0; w < BW; w++) begin
      for (int k = 0; k < 2; k++) begin
        drv(0, 0, 1'b1, k, w, 4'hF, 1'b1, 1'b0, 1'b0, pat(k, w, 1));
        drv(1, 0, 1'b1, 2 + k, w, 4'hF, 1'b1, 1'b0, 1'b0, pat(2 + k, w, 2));
        wrRef(k, w, 4'hF, pat(k, w, 1));
        wrRef(2 + k, w, 4'hF, pat(2 + k, w, 2));
        tick();
      end
    end

    // cross reads in flow-through mode
    for (int k = 0; k < 2; k++) begin
      for (int w = 0; w < BW; w++) begin
        drv(0, 0, 1'b0, 2 + k, w, 4'hF, 1'b1, 1'b0, 1'b0, '0);
        drv(1, 0, 1'b0, k, w, 4'hF, 1'b1, 1'b0, 1'b0, '0);
        tick();
        check("R1/R5 A reads B-written bank", aDout, refMem[(2 + k)*BW + w]);
        check("R3 B reads A-written bank", bDout, refMem[k*BW + w]);
      end
    end

    // pipelined sweep
    idle(0); idle(1);
    tick();
    aPipe = 1'b1; bPipe = 1'b1;
    tick();
    for (int i = 0; i <= BW; i++) begin
      if (i < BW) begin
        drv(0, 0, 1'b0, 0, i, 4'hF, 1'b1, 1'b0, 1'b0, '0);
        drv(1, 0, 1'b0, 3, i, 4'hF, 1'b1, 1'b0, 1'b0, '0);
      end else begin
        idle(0); idle(1);
      end
      tick();
      if (i == 0) begin
        check("R6 pipelined A not yet valid", aDout, '0);
        check("R6 pipelined B not yet valid", bDout, '0);
      end else begin
        check("R6 pipelined A", aDout, refMem[0*BW + i - 1]);
        check("R6 pipelined B", bDout, refMem[3*BW + i - 1]);
      end
    end
    aPipe = 1'b0; bPipe = 1'b0;
    idle(0); idle(1);
    tick();

    // lane masks, alternating writer, other port reads
    for (int m = 0; m < 16; m++) begin
      int wp = m % 2;
      drv(wp, 0, 1'b1, 1, 5, 4'(m), 1'b1, 1'b0, 1'b0, pat(1, 5, m + 3));
      wrRef(1, 5, 4'(m), pat(1, 5, m + 3));
      tick();
      idle(wp);
      drv(1 - wp, 0, 1'b0, 1, 5, 4'hF, 1'b1, 1'b0, 1'b0, '0);
      tick();
      check("R4/R12 masked write read full", (wp == 0) ? bDout : aDout, refMem[1*BW + 5]);
      drv(1 - wp, 0, 1'b0, 1, 5, 4'(m), 1'b1, 1'b0, 1'b0, '0);
      tick();
      check("R4 masked read", (wp == 0) ? bDout : aDout, refMem[1*BW + 5] & lm(4'(m)));
      idle(1 - wp);
    end

    // counter burst write with wrap in bank 2
    drv(0, 0, 1'b1, 2, 14, 4'hF, 1'b1, 1'b0, 1'b0, pat(2, 14, 9));
    wrRef(2, 14, 4'hF, pat(2, 14, 9));
    tick();
    for (int i = 1; i < 5; i++) begin
      drv(0, 0, 1'b1, 2, 0, 4'hF, 1'b0, 1'b1, 1'b0, pat(2, (14 + i) % BW, 9));
      wrRef(2, (14 + i) % BW, 4'hF, pat(2, (14 + i) % BW, 9));
      tick();
    end
    idle(0);
    for (int i = 0; i < 5; i++) begin
      drv(1, 0, 1'b0, 2, (14 + i) % BW, 4'hF, 1'b1, 1'b0, 1'b0, '0);
      tick();
      check("R8 burst wrote wrapped word", bDout, pat(2, (14 + i) % BW, 9));
    end
    idle(1);

    // counter reads, repeat, hold, priorities
    drv(0, 0, 1'b0, 2, 14, 4'hF, 1'b1, 1'b0, 1'b0, '0); tick();
    check("R7 strobe load", aDout, refMem[2*BW + 14]);
    drv(0, 0, 1'b0, 2, 3, 4'hF, 1'b0, 1'b1, 1'b0, '0); tick();
    check("R8 count step", aDout, refMem[2*BW + 15]);
    drv(0, 0, 1'b0, 2, 3, 4'hF, 1'b0, 1'b1, 1'b0, '0); tick();
    check("R8 count wrap", aDout, refMem[2*BW + 0]);
    drv(0, 0, 1'b0, 2, 3, 4'hF, 1'b0, 1'b0, 1'b1, '0); tick();
    check("R9 repeat", aDout, refMem[2*BW + 14]);
    drv(0, 0, 1'b0, 2, 3, 4'hF, 1'b0, 1'b0, 1'b0, '0); tick();
    check("R8 hold", aDout, refMem[2*BW + 14]);
    drv(0, 0, 1'b0, 2, 3, 4'hF, 1'b0, 1'b1, 1'b1, '0); tick();
    check("R9 repeat beats count", aDout, refMem[2*BW + 14]);
    drv(0, 0, 1'b0, 2, 1, 4'hF, 1'b1, 1'b0, 1'b1, '0); tick();
    check("R7 strobe beats repeat", aDout, refMem[2*BW + 1]);
    drv(0, 0, 1'b0, 2, 0, 4'hF, 1'b1, 1'b0, 1'b0, '0); tick();
    drv(0, 0, 1'b0, 3, 9, 4'hF, 1'b0, 1'b1, 1'b0, '0); tick();
    check("R8 count with new bank", aDout, refMem[3*BW + 1]);

    // deselect
    drv(0, 0, 1'b0, 0, 9, 4'hF, 1'b1, 1'b0, 1'b0, '0); tick();
    check("R2 selected read", aDout, refMem[0*BW + 9]);
    drv(0, 1, 1'b1, 0, 2, 4'hF, 1'b1, 1'b1, 1'b0, 36'hFFFFFFFFF); tick();
    check("R2 first enable off output", aDout, '0);
    drv(0, 2, 1'b1, 0, 2, 4'hF, 1'b1, 1'b1, 1'b0, 36'hFFFFFFFFF); tick();
    check("R2 second enable off output", aDout, '0);
    drv(0, 0, 1'b0, 0, 2, 4'hF, 1'b0, 1'b1, 1'b0, '0); tick();
    check("R2 counter held and no write", aDout, refMem[0*BW + 10]);
    drv(0, 0, 1'b0, 0, 2, 4'hF, 1'b1, 1'b0, 1'b0, '0); tick();
    check("R2 no write by deselected strobe", aDout, refMem[0*BW + 2]);

    // output enable
    drv(0, 0, 1'b0, 1, 7, 4'hF, 1'b1, 1'b0, 1'b0, '0); tick();
    idle(0);
    check("R10 enabled", aDout, refMem[1*BW + 7]);
    aOeN = 1'b1; #1;
    check("R10 disabled", aDout, '0);
    aOeN = 1'b0; #1;
    check("R10 re-enabled", aDout, refMem[1*BW + 7]);
    tick();

    finishRun();
  end
endmodule